// File: doc/BRIEF.md
# Configuration Register Attribute Engine

This block holds the configuration register space of one function on a bus that addresses registers by DWORD. Each request carries a function number, a DWORD offset, four byte enables and, for writes, 32 bits of data. The block claims the request only when the function number matches its own. When it claims a request, each byte of the addressed register is updated according to that byte's attribute. One cycle after any request, the block returns a response flag, a claim flag and the read data.

The register map is fixed. Offset 0 is a constant identity word. The remaining registers each demonstrate one attribute class:

| Offset | Register | Attribute |
|--------|----------|-----------|
| 0 | identity | read-only |
| 1 | scratch | read/write |
| 2 | status | set by a hardware input, cleared by writing 1 |
| 3 | lock-after-write | write-once, locked per byte |
| 4 | sticky | write-1-only, cleared only by reset |

Every other offset is implemented as empty space.

A reset that is synchronous and active high returns every register to its default and unlocks every write-once byte.

Top module: `cfg_attr_regs`

## Requirements
- R1: A request whose function number differs from FUNC_NUM is not claimed. The response has rsp_claim low and rsp_rdata zero, and no register changes.
- R2: A claimed request to an offset of 5 or more is claimed. A write to such an offset changes nothing, and a read returns zero.
- R3: A read of offset 0 returns {DEV_ID, VEN_ID}, with the device number in bits 31:16 and the vendor number in bits 15:0. Writes to offset 0 have no effect.
- R4: Offset 1 is read/write. A write replaces exactly the bytes whose enable is high, where enable bit b selects data bits 8b+7:8b.
- R5: Offset 3 is write-once per byte. The first write with a byte's enable high stores that byte and locks it. Later writes to a locked byte are ignored until reset. A byte whose enable was low stays unlocked.
- R6: Offset 2 is status. hw_set bit i high in a cycle sets status bit i. A claimed write clears the enabled bits that carry 1, and data bits that carry 0 leave their status bits unchanged.
- R7: Offset 4 is write-1-only. A write sets the enabled bits that carry 1. No write clears a bit; only reset does.
- R8: If hw_set bit i and a write-1 clear of status bit i occur in the same cycle, the bit is 1 afterwards.
- R9: rsp_valid follows req_valid by exactly one cycle. Read data reflects the register contents before that cycle's update. Writes return zero data. A read in the cycle after a write sees the written value.
- R10: After reset, every register except the identity word reads zero, and every write-once byte is writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_func | input | FUNC_W | Function number of the request |
| req_addr | input | ADDR_W | DWORD offset |
| req_be | input | 4 | Byte enables, bit b selects data byte b |
| req_wdata | input | 32 | Write data |
| hw_set | input | 32 | Hardware set pulses for the status register |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_claim | output | 1 | Request was claimed |
| rsp_rdata | output | 32 | Read data (zero for writes and unclaimed requests) |

## Verification
The assertions assume that reset is held for at least one clock edge before requests start. They also assume that hw_set is a level that is sampled on every edge, with no handshake. The stimulus starts requests only after reset has been released. It changes inputs only on the falling clock edge. It draws function numbers, offsets, byte enables, data and sparse hw_set masks freely, so collisions between a hardware set and a software clear arise on their own. Directed sequences cover filling write-once bytes one at a time, reset in the middle of a run, and writes to the wrong function or to empty offsets.

// File: rtl/cfg_attr_pkg.sv
package cfg_attr_pkg;

    localparam int DATA_W  = 32;
    localparam int BYTES   = DATA_W / 8;
    localparam int NREG    = 5;
    localparam int REG_ID  = 0;
    localparam int REG_RW  = 1;
    localparam int REG_ST  = 2;
    localparam int REG_WO  = 3;
    localparam int REG_W1O = 4;

    typedef enum logic [2:0] {
        ATTR_RO,
        ATTR_RW,
        ATTR_W1C,
        ATTR_WO,
        ATTR_W1O
    } attr_e;

    function automatic attr_e attr_of(input int idx);
        case (idx)
            REG_RW:  return ATTR_RW;
            REG_ST:  return ATTR_W1C;
            REG_WO:  return ATTR_WO;
            REG_W1O: return ATTR_W1O;
            default: return ATTR_RO;
        endcase
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode #(
    parameter int FUNC_W   = 3,
    parameter int ADDR_W   = 6,
    parameter int FUNC_NUM = 0,
    parameter int NREG     = 5
) (
    input  logic              req_valid,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              claim,
    output logic [NREG-1:0]   hit
);
    assign claim = req_valid && (req_func == FUNC_W'(FUNC_NUM));

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = claim && (req_addr == ADDR_W'(i));
    end
endmodule

// File: rtl/cfg_attr_lane.sv
module cfg_attr_lane
    import cfg_attr_pkg::*;
#(
    parameter attr_e ATTR = ATTR_RW
) (
    input  logic [7:0] cur,
    input  logic       locked,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic [7:0] hw,
    output logic [7:0] nxt
);
    localparam bit IS_LOAD = (ATTR == ATTR_RW) || (ATTR == ATTR_WO);
    localparam bit IS_W1C  = (ATTR == ATTR_W1C);
    localparam bit IS_W1O  = (ATTR == ATTR_W1O);

    logic       eff;
    logic [7:0] wmask;

    assign eff   = wr_en && !locked;
    assign wmask = eff ? wdata : 8'h00;

    always_comb begin
        if (IS_LOAD)      nxt = eff ? wdata : cur;
        else if (IS_W1C)  nxt = (cur & ~wmask) | hw;
        else if (IS_W1O)  nxt = cur | wmask;
        else              nxt = cur;
    end
endmodule

// File: rtl/cfg_attr_regs.sv
module cfg_attr_regs
    import cfg_attr_pkg::*;
#(
    parameter int          FUNC_W   = 3,
    parameter int          ADDR_W   = 6,
    parameter int          FUNC_NUM = 0,
    parameter logic [15:0] DEV_ID   = 16'h5A3C,
    parameter logic [15:0] VEN_ID   = 16'hC0DE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       hw_set,
    output logic              rsp_valid,
    output logic              rsp_claim,
    output logic [31:0]       rsp_rdata
);
    localparam logic [DATA_W-1:0] ID_WORD = {DEV_ID, VEN_ID};

    typedef struct packed {
        logic [NREG-1:1][DATA_W-1:0] val;
        logic [BYTES-1:0]            wo_lock;
        logic                        rsp_valid;
        logic                        rsp_claim;
        logic [DATA_W-1:0]           rsp_rdata;
    } state_t;

    state_t st_d, st_q;

    logic                        claim;
    logic [NREG-1:0]             hit;
    logic [NREG-1:1][DATA_W-1:0] lane_nxt;

    cfg_decode #(
        .FUNC_W  (FUNC_W),
        .ADDR_W  (ADDR_W),
        .FUNC_NUM(FUNC_NUM),
        .NREG    (NREG)
    ) dec_i (
        .req_valid(req_valid),
        .req_func (req_func),
        .req_addr (req_addr),
        .claim    (claim),
        .hit      (hit)
    );

    for (genvar r = 1; r < NREG; r++) begin : g_reg
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            cfg_attr_lane #(.ATTR(attr_of(r))) lane_i (
                .cur   (st_q.val[r][b*8 +: 8]),
                .locked((r == REG_WO) ? st_q.wo_lock[b] : 1'b0),
                .wr_en (hit[r] && req_write && req_be[b]),
                .wdata (req_wdata[b*8 +: 8]),
                .hw    ((r == REG_ST) ? hw_set[b*8 +: 8] : 8'h00),
                .nxt   (lane_nxt[r][b*8 +: 8])
            );
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.val       = lane_nxt;
        for (int b = 0; b < BYTES; b++) begin
            st_d.wo_lock[b] = st_q.wo_lock[b] |
                              (hit[REG_WO] && req_write && req_be[b]);
        end
        st_d.rsp_valid = req_valid;
        st_d.rsp_claim = claim;
        st_d.rsp_rdata = '0;
        if (claim && !req_write) begin
            if (hit[REG_ID]) st_d.rsp_rdata = ID_WORD;
            for (int i = 1; i < NREG; i++) begin
                if (hit[i]) st_d.rsp_rdata = st_q.val[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_claim = st_q.rsp_claim;
    assign rsp_rdata = st_q.rsp_rdata;

    AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_claim) |-> (rsp_rdata == '0)); // R1
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_claim)); // R9
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.val[REG_W1O] & $past(st_q.val[REG_W1O])) ==
                  $past(st_q.val[REG_W1O]))); // R7
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((st_q.val[REG_ST] & $past(hw_set)) == $past(hw_set))); // R8
    for (genvar b = 0; b < BYTES; b++) begin : g_wo_chk
        AST_WO_LOCK_STABLE: assert property (@(posedge clk) disable iff (rst)
            st_q.wo_lock[b] |=> $stable(st_q.val[REG_WO][b*8 +: 8])); // R5
        AST_WO_LOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
            st_q.wo_lock[b] |=> st_q.wo_lock[b]); // R5
    end
endmodule

// File: tb/cfg_attr_regs_tb.sv
`timescale 1ns/1ps
module cfg_attr_regs_tb_top;
    localparam logic [2:0]  FN  = 3'd0;
    localparam logic [31:0] IDW = 32'h5A3C_C0DE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_func = '0;
    logic [5:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0, hw_set = '0;
    logic        rsp_valid, rsp_claim;
    logic [31:0] rsp_rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] m_rw, m_st, m_wo, m_w1o;
    logic [3:0]  m_lock;

    always #2.5 clk = ~clk;

    cfg_attr_regs dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_func(req_func), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .hw_set(hw_set), .rsp_valid(rsp_valid),
        .rsp_claim(rsp_claim), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] bemask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a);
        case (a)
            6'd0: return IDW;
            6'd1: return m_rw;
            6'd2: return m_st;
            6'd3: return m_wo;
            6'd4: return m_w1o;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'd0: return "R3";
            6'd1: return "R4";
            6'd2: return "R6";
            6'd3: return "R5";
            6'd4: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_rw = '0; m_st = '0; m_wo = '0; m_w1o = '0; m_lock = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; hw_set = '0;
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic xact(input bit wr, input logic [2:0] fn, input logic [5:0] a,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic [31:0] hw, input string tag);
        bit          cl = (fn == FN);
        logic [31:0] exp = (cl && !wr) ? model_read(a) : 32'h0;
        logic [31:0] m = bemask(be);
        req_valid = 1'b1; req_write = wr; req_func = fn; req_addr = a;
        req_be = be; req_wdata = wd; hw_set = hw;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; hw_set = '0;
        check({tag, " valid R9"}, {31'h0, rsp_valid}, 32'h1);
        check({tag, " claim R1"}, {31'h0, rsp_claim}, {31'h0, cl});
        check(tag, rsp_rdata, exp);
        if (cl && wr) begin
            case (a)
                6'd1: m_rw = (m_rw & ~m) | (wd & m);
                6'd2: m_st = m_st & ~(wd & m);
                6'd3: for (int b = 0; b < 4; b++)
                          if (be[b] && !m_lock[b]) begin
                              m_wo[b*8 +: 8] = wd[b*8 +: 8];
                              m_lock[b] = 1'b1;
                          end
                6'd4: m_w1o = m_w1o | (wd & m);
                default: ;
            endcase
        end
        m_st = m_st | hw;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        xact(1'b0, FN, a, 4'hF, 32'h0, 32'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R10 reset state, R3 identity, R2 empty offset
        rd(6'd0, "R3 id after reset");
        for (int a = 1; a < 6; a++) rd(6'(a), "R10 reset value");
        // R9 idle: no response without a request
        @(posedge clk); @(negedge clk);
        check("R9 idle valid", {31'h0, rsp_valid}, 32'h0);
        // R3 write to identity ignored
        xact(1'b1, FN, 6'd0, 4'hF, 32'hFFFF_FFFF, 32'h0, "R3 write id");
        rd(6'd0, "R3 id unchanged");
        // R4 partial byte enables; R9 read right after write
        xact(1'b1, FN, 6'd1, 4'b0101, 32'h1122_3344, 32'h0, "R4 write");
        rd(6'd1, "R4 partial");
        xact(1'b1, FN, 6'd1, 4'b1010, 32'hAABB_CCDD, 32'h0, "R4 write2");
        rd(6'd1, "R9 R4 merged");
        // R5 per-byte fill of write-once
        xact(1'b1, FN, 6'd3, 4'b0001, 32'h0000_00A5, 32'h0, "R5 byte0");
        rd(6'd3, "R5 byte0 only");
        xact(1'b1, FN, 6'd3, 4'b1111, 32'h5566_7788, 32'h0, "R5 rest");
        rd(6'd3, "R5 filled");
        xact(1'b1, FN, 6'd3, 4'b1111, 32'h0, 32'h0, "R5 locked write");
        rd(6'd3, "R5 locked");
        // R6 status set, clear by 1, zero has no effect
        xact(1'b0, FN, 6'd5, 4'hF, 32'h0, 32'h8000_0F01, "R2 read empty with hw");
        rd(6'd2, "R6 hw set");
        xact(1'b1, FN, 6'd2, 4'hF, 32'h0, 32'h0, "R6 write zero");
        rd(6'd2, "R6 zero no effect");
        xact(1'b1, FN, 6'd2, 4'hF, 32'h0000_0101, 32'h0, "R6 clear");
        rd(6'd2, "R6 cleared");
        // R8 simultaneous set and clear
        xact(1'b1, FN, 6'd2, 4'hF, 32'h8000_0E00, 32'h8000_0000, "R8 collide");
        rd(6'd2, "R8 hw wins");
        // R7 write-1-only
        xact(1'b1, FN, 6'd4, 4'hF, 32'h00F0_0F0F, 32'h0, "R7 set");
        xact(1'b1, FN, 6'd4, 4'hF, 32'h0, 32'h0, "R7 zero");
        rd(6'd4, "R7 sticky");
        // R1 wrong function: not claimed, no change
        xact(1'b1, 3'd5, 6'd1, 4'hF, 32'hDEAD_BEEF, 32'h0, "R1 foreign write");
        xact(1'b0, 3'd5, 6'd1, 4'hF, 32'h0, 32'h0, "R1 foreign read");
        rd(6'd1, "R1 rw unchanged");
        // R2 empty offset write and read
        xact(1'b1, FN, 6'd7, 4'hF, 32'h1234_5678, 32'h0, "R2 write empty");
        rd(6'd7, "R2 read empty");
        // R10 reset in the middle unlocks write-once
        do_reset();
        rd(6'd4, "R10 sticky cleared");
        xact(1'b1, FN, 6'd3, 4'b1111, 32'hCAFE_F00D, 32'h0, "R10 wo again");
        rd(6'd3, "R10 wo writable");
        // constrained random
        for (int n = 0; n < 800; n++) begin
            logic [5:0]  a   = 6'($urandom % 8);
            logic [2:0]  fn  = (($urandom % 8) == 0) ? 3'd5 : FN;
            logic [31:0] hw  = $urandom & $urandom & $urandom & $urandom;
            bit          wr  = 1'($urandom % 2);
            xact(wr, fn, a, 4'($urandom % 16), $urandom, hw, tag_of(a));
            if (($urandom % 200) == 0) do_reset();
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule